// File: doc/BRIEF.md
# Power Rail Sequencer

This block switches a set of power-enable outputs on one at a time and later switches them off in the reverse order. A one-hot step register moves forward by one position on each slow step strobe. The strobe comes from a divider on the system clock, and by default it fires once per second. The first positions set the rail enables one after another. The register then pauses with every rail on. It waits there until an operator release is seen. After the release, the following positions clear the rails from the last one back to the first. The sequence ends in a terminal position that only a reset leaves.

Each rail enable is a held latch. It stays set after the step register has moved past the position that set it. The latches and the step register share an asynchronous active-low reset. Because of that reset, every rail starts cleared and never comes up in an unknown state. A rail changes on the same clock edge on which the step register moves.

Top module: `rail_sequencer`

## Requirements
- R1: While `rst_n` is low, the step register is at position 0, `rail_en_o` is all zeros, and `all_on_o` and `done_o` are 0. The reset acts without waiting for a clock edge, even in the middle of a sequence.
- R2: The internal strobe is one clock cycle wide and fires once every CLK_HZ/STEP_HZ clocks. Two consecutive changes of `rail_en_o` are exactly that many clocks apart.
- R3: After reset, bit k-1 of `rail_en_o` is set at position k, for k = 1..N_RAILS. The bits come on from bit 0 upward, one per step, and each one stays set.
- R4: At position N_RAILS, `all_on_o` is 1 and `rail_en_o` is all ones. The register does not advance on any further strobe until a release has been captured.
- R5: A high `release_i` is captured only while `all_on_o` is 1. Once captured, it lets the next strobe advance the register, so a one-cycle pulse is enough. A release seen at any other position leaves no trace.
- R6: After the release, positions N_RAILS+1 .. 2*N_RAILS clear the rails one per step, from bit N_RAILS-1 down to bit 0.
- R7: At position 2*N_RAILS+1, `done_o` is 1 and `rail_en_o` is zero. The block stays there, whatever `release_i` does, until reset.
- R8: Exactly one step position is active at any time. `all_on_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| release_i | input | 1 | Debounced operator release, active high |
| rail_en_o | output | N_RAILS | Held rail enables; bit 0 is the first rail |
| all_on_o | output | 1 | High while paused with every rail on |
| done_o | output | 1 | High in the terminal position |

## Verification
The hardest case to reach is a release that lands on the wrong step. One example is a release during the ramp-up, which must not stop the pause from happening. Another is a release that arrives on the same clock as a strobe while the block is paused. The bench uses a shortened divider, CLK_HZ=6. It places release pulses at chosen points in the sequence, measured against its reference model: during the ramp-up, during the pause, and after the terminal position. It then fires an asynchronous reset partway through a second run.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // Number of one-hot positions for a given rail count: idle, N set steps,
  // N clear steps, and the terminal position.
  function automatic int unsigned n_positions(input int unsigned n_rails);
    return 2 * n_rails + 2;
  endfunction

  // Position at which rail k (1-based) is cleared on the way down.
  function automatic int unsigned clear_step(input int unsigned n_rails, input int unsigned k);
    return 2 * n_rails + 1 - k;
  endfunction
endpackage

// File: rtl/step_tick_gen.sv
module step_tick_gen #(
  parameter int unsigned DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/step_ring.sv
module step_ring #(
  parameter int unsigned N_RAILS = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        tick,
  input  logic                                        release_i,
  output logic [seq_pkg::n_positions(N_RAILS)-1:0]    pos,
  output logic [seq_pkg::n_positions(N_RAILS)-1:0]    pos_nxt,
  output logic                                        adv,
  output logic                                        armed
);
  localparam int unsigned PW = seq_pkg::n_positions(N_RAILS);
  localparam int unsigned HOLD = N_RAILS;
  localparam int unsigned LAST = PW - 1;

  logic at_hold, at_last;

  assign at_hold = pos[HOLD];
  assign at_last = pos[LAST];
  assign adv     = tick & ~at_last & (~at_hold | armed);
  assign pos_nxt = adv ? {pos[PW-2:0], 1'b0} : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= PW'(1);
      armed <= 1'b0;
    end else begin
      pos   <= pos_nxt;
      armed <= at_hold & ~adv & (armed | release_i);
    end
  end
endmodule

// File: rtl/rail_latches.sv
module rail_latches #(
  parameter int unsigned N_RAILS = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     adv,
  input  logic [seq_pkg::n_positions(N_RAILS)-1:0] pos_nxt,
  output logic [N_RAILS-1:0]                       rail_en
);
  for (genvar k = 1; k <= N_RAILS; k++) begin : g_rail
    localparam int unsigned CLR = seq_pkg::clear_step(N_RAILS, k);
    logic set_k, clr_k;
    assign set_k = adv & pos_nxt[k];
    assign clr_k = adv & pos_nxt[CLR];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rail_en[k-1] <= 1'b0;
      else if (set_k) rail_en[k-1] <= 1'b1;
      else if (clr_k) rail_en[k-1] <= 1'b0;
    end
  end
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int unsigned N_RAILS = 4,
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned STEP_HZ = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               release_i,
  output logic [N_RAILS-1:0] rail_en_o,
  output logic               all_on_o,
  output logic               done_o
);
  localparam int unsigned DIV = CLK_HZ / STEP_HZ;
  localparam int unsigned PW  = seq_pkg::n_positions(N_RAILS);

  logic          tick, adv, armed;
  logic [PW-1:0] pos, pos_nxt;

  step_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  step_ring #(.N_RAILS(N_RAILS)) u_ring (
    .clk(clk), .rst_n(rst_n), .tick(tick), .release_i(release_i),
    .pos(pos), .pos_nxt(pos_nxt), .adv(adv), .armed(armed)
  );

  rail_latches #(.N_RAILS(N_RAILS)) u_rails (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pos_nxt(pos_nxt), .rail_en(rail_en_o)
  );

  assign all_on_o = pos[N_RAILS];
  assign done_o   = pos[PW-1];
endmodule

// File: rtl/seq_sva.sv
module seq_sva #(
  parameter int unsigned N_RAILS = 4
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic [N_RAILS-1:0]                       rail_en_o,
  input logic                                     all_on_o,
  input logic                                     done_o,
  input logic [seq_pkg::n_positions(N_RAILS)-1:0] pos,
  input logic                                     tick,
  input logic                                     adv,
  input logic                                     armed
);
  AST_ONE_POSITION: assert property (@(posedge clk) disable iff (!rst_n) $countones(pos) == 1); // R8
  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(all_on_o && done_o)); // R8
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) adv |-> tick); // R2
  AST_ONE_RAIL_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $countones(rail_en_o ^ $past(rail_en_o)) <= 1); // R3
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n) all_on_o |-> (&rail_en_o)); // R4
  AST_HOLD_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (all_on_o && !armed) |=> all_on_o); // R4
  AST_ARM_ONLY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) armed |-> all_on_o); // R5
  AST_TERMINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> (done_o && rail_en_o == '0)); // R7
endmodule

bind rail_sequencer seq_sva #(.N_RAILS(N_RAILS)) u_sva (
  .clk(clk), .rst_n(rst_n), .rail_en_o(rail_en_o), .all_on_o(all_on_o),
  .done_o(done_o), .pos(pos), .tick(tick), .adv(adv), .armed(armed)
);

// File: tb/test_rail_sequencer.sv
`timescale 1ns/1ps
module test_rail_sequencer;
  localparam int N   = 4;
  localparam int DIV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic release_i = 1'b0;
  logic [N-1:0] rail_en_o;
  logic all_on_o, done_o;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state
  int m_pos = 0, m_cnt = 0, m_armed = 0;
  bit m_tick = 0;
  logic [N-1:0] m_rails = '0;

  // order/gap monitor state
  logic [N-1:0] prev_rails = '0;
  int last_change = -1, cyc = 0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.N_RAILS(N), .CLK_HZ(DIV), .STEP_HZ(1)) i_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .release_i(release_i),
    .rail_en_o(rail_en_o), .all_on_o(all_on_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: strobe every DIV clocks, pause at N, stop at 2N+1
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_cnt = 0; m_tick = 0; m_armed = 0; m_rails = '0;
    end else begin
      bit step;
      step = m_tick && (m_pos != 2*N+1) && (m_pos != N || m_armed != 0);
      if (m_pos == N && !step && (m_armed != 0 || release_i)) m_armed = 1;
      else m_armed = 0;
      if (step) begin
        m_pos++;
        if (m_pos <= N) m_rails[m_pos-1] = 1'b1;
        else if (m_pos <= 2*N) m_rails[2*N-m_pos] = 1'b0;
      end
      m_tick = (m_cnt == DIV-1);
      m_cnt  = (m_cnt == DIV-1) ? 0 : m_cnt + 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R3/R6 rails vs model", 32'(rail_en_o), 32'(m_rails));
      check("R4 all_on vs model", 32'(all_on_o), 32'(m_pos == N));
      check("R7 done vs model", 32'(done_o), 32'(m_pos == 2*N+1));
      if (rail_en_o != prev_rails) begin
        if (rail_en_o > prev_rails)
          check("R3 next rail on", 32'(rail_en_o), 32'((prev_rails << 1) | 1));
        else
          check("R6 reverse off", 32'(rail_en_o), 32'(prev_rails >> 1));
        if (last_change >= 0 && !$past(all_on_o, 1) && prev_rails != '1)
          check("R2 step spacing", 32'(cyc - last_change), 32'(DIV));
        last_change = cyc;
      end
    end else begin
      last_change = -1;
    end
    prev_rails = rail_en_o;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_release();
    release_i = 1'b1;
    @(negedge clk);
    release_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    wait_cycles(3);
    check("R1 rails in reset", 32'(rail_en_o), 0);
    check("R1 all_on in reset", 32'(all_on_o), 0);
    check("R1 done in reset", 32'(done_o), 0);
    rst_n = 1'b1;

    // early release during ramp-up must be ignored (R5)
    while (rail_en_o != 4'b0011) @(negedge clk);
    pulse_release();
    wait_cycles(2);
    pulse_release();
    while (!all_on_o) @(negedge clk);
    check("R4 all rails on at hold", 32'(rail_en_o), 32'((1 << N) - 1));
    wait_cycles(5*DIV);
    check("R5 early release ignored, still paused", 32'(all_on_o), 1);
    check("R4 rails held during pause", 32'(rail_en_o), 32'((1 << N) - 1));

    // one-cycle release pulse while paused
    pulse_release();
    wait_cycles(2*DIV + 2);
    check("R5 release in pause leaves hold", 32'(all_on_o), 0);
    while (!done_o) @(negedge clk);
    check("R7 rails off at terminal", 32'(rail_en_o), 0);
    pulse_release();
    wait_cycles(4*DIV);
    check("R7 terminal holds after release", 32'(done_o), 1);
    check("R7 rails stay off", 32'(rail_en_o), 0);

    // second run: asynchronous reset mid-ramp
    rst_n = 1'b0; wait_cycles(2); rst_n = 1'b1;
    while (rail_en_o != 4'b0111) @(negedge clk);
    #1.0 rst_n = 1'b0;
    #0.5;
    check("R1 async reset clears rails", 32'(rail_en_o), 0);
    check("R1 async reset clears all_on", 32'(all_on_o), 0);
    wait_cycles(2);
    rst_n = 1'b1;
    // release at same clock as a strobe while paused
    while (!all_on_o) @(negedge clk);
    check("R8 status exclusive", 32'(all_on_o & done_o), 0);
    while (!i_rail_sequencer.all_on_o || m_cnt != 0) @(negedge clk);
    pulse_release();
    while (!done_o) @(negedge clk);
    check("R6 all off after release", 32'(rail_en_o), 0);
    wait_cycles(3);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule